// File: doc/BRIEF.md
# PCI Configuration Access Port

This block lets a host CPU reach the configuration space of devices behind a host bridge through two registers on a small register bus. A selector register holds the target's bus, device, function and dword register index together with a gate bit. A data window then turns each CPU access into one configuration cycle on a simple target-side interface. That interface carries a request, the decoded address fields, byte enables, write data, a ready return and read data.

The CPU presents an access on `cpuReq` with an offset, a direction, a size in bytes and right-aligned write data. It holds these until `cpuDone` pulses. A data-window access waits for the target's ready before it completes, and this holds for writes as well as reads. Narrow accesses are steered onto the byte lanes chosen by the two low offset bits. On reads, narrow data is returned right-aligned.

Top module: `cfgAccessPort`

## Requirements
- R1: After reset `cpuDone`, `cpuErr` and `tgtReq` are low, and a word read of the selector register (offset 0x28) returns 0.
- R2: A 4-byte write to offset 0x28 stores all 32 bits into the selector, and a later 4-byte read there returns them unchanged. Any other size, or a nonzero low offset, at the selector completes with `cpuErr` high and leaves the selector unchanged.
- R3: While `tgtReq` is high, `tgtBus` equals selector bits 23:16, `tgtDev` bits 15:11, `tgtFunc` bits 10:8 and `tgtReg` bits 7:2. Selector bits 1:0 do not reach the target.
- R4: Accesses to the data window (offsets 0x2C to 0x2F) issue a target cycle only while selector bit 31 is set. With bit 31 clear, the access completes with no `tgtReq`, read data 0 and no error.
- R5: `tgtBe` is 0001 shifted left by the offset for 1-byte accesses, 0011 shifted left by the offset for 2-byte accesses, and 1111 for 4-byte accesses. `tgtWrite` follows the CPU direction.
- R6: `tgtWdata` is `cpuWdata` shifted left by 8 times the low offset.
- R7: A data-window read returns the target word shifted right by 8 times the low offset, keeping 8, 16 or 32 bits for sizes 1, 2 and 4.
- R8: `tgtReq` stays high until `tgtReady` is sampled. `cpuDone` pulses in the cycle after that, and never before it.
- R9: A data-window access whose size is not 1, 2 or 4, or whose lanes cross the dword (2 bytes at offset 3, 4 bytes at a nonzero offset), completes with `cpuErr` high and issues no target cycle.
- R10: `cpuDone` is a single-cycle pulse, and `cpuErr` is high only together with it. Any other offset completes with read data 0 and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReq | input | 1 | Access request, held until cpuDone |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | CPU_AW | Register offset |
| cpuSize | input | 3 | Access size in bytes |
| cpuWdata | input | 32 | Right-aligned write data |
| cpuRdata | output | 32 | Right-aligned read data, valid with cpuDone |
| cpuDone | output | 1 | Completion pulse |
| cpuErr | output | 1 | Access rejected, valid with cpuDone |
| tgtReq | output | 1 | Configuration cycle request |
| tgtWrite | output | 1 | Cycle direction |
| tgtBus | output | 8 | Bus number |
| tgtDev | output | 5 | Device number |
| tgtFunc | output | 3 | Function number |
| tgtReg | output | 6 | Dword register index |
| tgtBe | output | 4 | Byte enables |
| tgtWdata | output | 32 | Lane-steered write data |
| tgtReady | input | 1 | Target completion |
| tgtRdata | input | 32 | Target read word |

## Verification
The data window is swept over every size from 0 to 7 at each of the four low offsets, for both directions and under several selector values whose fields differ. This separates lane selection, shift direction and masking errors from field-slicing errors. The target latency is varied from zero to two wait cycles, which shows whether completion truly waits for ready. Separate passes with the gate bit clear, with bad-size accesses to the selector, and at an unmapped offset show that no target cycle leaks out and that the selector stays intact.

// File: rtl/cfg_pkg.sv
package cfgPkg;
  // Strobes from the controller to the datapath
  typedef struct packed {
    logic loadSel;   // store write data into selector
    logic rdSel;     // return selector as read data
    logic rdTarget;  // return steered target read data
    logic rdZero;    // return zero read data
    logic setErr;    // flag the access as rejected
  } ctlStrobes_t;

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_DONE} ctlState_t;
endpackage

// File: rtl/cfg_datapath.sv
module cfgDatapath
  import cfgPkg::*;
#(
  parameter int CPU_AW = 8,
  parameter logic [CPU_AW-1:0] SEL_OFF = 8'h28,
  parameter logic [CPU_AW-1:0] WIN_OFF = 8'h2C
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       stb,
  input  logic [CPU_AW-1:0] cpuAddr,
  input  logic [2:0]        cpuSize,
  input  logic [31:0]       cpuWdata,
  input  logic [31:0]       tgtRdata,
  output logic              isSel,
  output logic              isWin,
  output logic              selWordOk,
  output logic              winSizeOk,
  output logic              gateOn,
  output logic [31:0]       cpuRdata,
  output logic              cpuErr,
  output logic [7:0]        tgtBus,
  output logic [4:0]        tgtDev,
  output logic [2:0]        tgtFunc,
  output logic [5:0]        tgtReg,
  output logic [3:0]        tgtBe,
  output logic [31:0]       tgtWdata
);
  localparam int DW_HI = CPU_AW - 1;

  logic [31:0] selReg;
  logic [1:0]  laneOff;
  logic [4:0]  shiftAmt;
  logic [31:0] shiftedRd;
  logic [31:0] sizeMask;

  assign laneOff  = cpuAddr[1:0];
  assign shiftAmt = {laneOff, 3'b000};

  assign isSel = (cpuAddr[DW_HI:2] == SEL_OFF[DW_HI:2]);
  assign isWin = (cpuAddr[DW_HI:2] == WIN_OFF[DW_HI:2]);
  assign selWordOk = (cpuSize == 3'd4) && (laneOff == 2'd0);
  assign winSizeOk = (cpuSize == 3'd1) ||
                     (cpuSize == 3'd2 && laneOff != 2'd3) ||
                     (cpuSize == 3'd4 && laneOff == 2'd0);
  assign gateOn = selReg[31];

  assign tgtBus  = selReg[23:16];
  assign tgtDev  = selReg[15:11];
  assign tgtFunc = selReg[10:8];
  assign tgtReg  = selReg[7:2];

  always_comb begin
    case (cpuSize)
      3'd1:    begin tgtBe = 4'b0001 << laneOff; sizeMask = 32'h0000_00FF; end
      3'd2:    begin tgtBe = 4'b0011 << laneOff; sizeMask = 32'h0000_FFFF; end
      default: begin tgtBe = 4'b1111;            sizeMask = 32'hFFFF_FFFF; end
    endcase
  end

  assign tgtWdata  = cpuWdata << shiftAmt;
  assign shiftedRd = (tgtRdata >> shiftAmt) & sizeMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg   <= '0;
      cpuRdata <= '0;
      cpuErr   <= 1'b0;
    end else begin
      if (stb.loadSel) selReg <= cpuWdata;
      if (stb.rdSel)         cpuRdata <= selReg;
      else if (stb.rdTarget) cpuRdata <= shiftedRd;
      else if (stb.rdZero || stb.setErr) cpuRdata <= '0;
      if (stb.loadSel || stb.rdSel || stb.rdTarget || stb.rdZero || stb.setErr)
        cpuErr <= stb.setErr;
      else
        cpuErr <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_control.sv
module cfgControl
  import cfgPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuReq,
  input  logic        cpuWrite,
  input  logic        isSel,
  input  logic        isWin,
  input  logic        selWordOk,
  input  logic        winSizeOk,
  input  logic        gateOn,
  input  logic        tgtReady,
  output ctlStrobes_t stb,
  output logic        tgtReq,
  output logic        cpuDone
);
  ctlState_t state, nextState;

  always_comb begin
    stb       = '0;
    nextState = state;
    case (state)
      ST_IDLE: if (cpuReq) begin
        nextState = ST_DONE;
        if (isSel) begin
          if (!selWordOk)    stb.setErr  = 1'b1;
          else if (cpuWrite) begin stb.loadSel = 1'b1; stb.rdZero = 1'b1; end
          else               stb.rdSel   = 1'b1;
        end else if (isWin) begin
          if (!winSizeOk)    stb.setErr  = 1'b1;
          else if (!gateOn)  stb.rdZero  = 1'b1;
          else               nextState   = ST_BUSY;
        end else begin
          stb.rdZero = 1'b1;
        end
      end
      ST_BUSY: if (tgtReady) begin
        nextState = ST_DONE;
        if (cpuWrite) stb.rdZero   = 1'b1;
        else          stb.rdTarget = 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign tgtReq  = (state == ST_BUSY);
  assign cpuDone = (state == ST_DONE);
endmodule

// File: rtl/cfg_access_port.sv
module cfgAccessPort
  import cfgPkg::*;
#(
  parameter int CPU_AW = 8,
  parameter logic [CPU_AW-1:0] SEL_OFF = 8'h28,
  parameter logic [CPU_AW-1:0] WIN_OFF = 8'h2C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWrite,
  input  logic [CPU_AW-1:0] cpuAddr,
  input  logic [2:0]        cpuSize,
  input  logic [31:0]       cpuWdata,
  output logic [31:0]       cpuRdata,
  output logic              cpuDone,
  output logic              cpuErr,
  output logic              tgtReq,
  output logic              tgtWrite,
  output logic [7:0]        tgtBus,
  output logic [4:0]        tgtDev,
  output logic [2:0]        tgtFunc,
  output logic [5:0]        tgtReg,
  output logic [3:0]        tgtBe,
  output logic [31:0]       tgtWdata,
  input  logic              tgtReady,
  input  logic [31:0]       tgtRdata
);
  ctlStrobes_t stb;
  logic isSel, isWin, selWordOk, winSizeOk, gateOn;

  assign tgtWrite = cpuWrite;

  cfgControl u_ctl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWrite(cpuWrite),
    .isSel(isSel), .isWin(isWin), .selWordOk(selWordOk), .winSizeOk(winSizeOk),
    .gateOn(gateOn), .tgtReady(tgtReady), .stb(stb), .tgtReq(tgtReq),
    .cpuDone(cpuDone)
  );

  cfgDatapath #(.CPU_AW(CPU_AW), .SEL_OFF(SEL_OFF), .WIN_OFF(WIN_OFF)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cpuAddr(cpuAddr), .cpuSize(cpuSize),
    .cpuWdata(cpuWdata), .tgtRdata(tgtRdata), .isSel(isSel), .isWin(isWin),
    .selWordOk(selWordOk), .winSizeOk(winSizeOk), .gateOn(gateOn),
    .cpuRdata(cpuRdata), .cpuErr(cpuErr), .tgtBus(tgtBus), .tgtDev(tgtDev),
    .tgtFunc(tgtFunc), .tgtReg(tgtReg), .tgtBe(tgtBe), .tgtWdata(tgtWdata)
  );
endmodule

// File: rtl/cfg_access_port_chk.sv
module cfgAccessPortChk (
  input logic       clk,
  input logic       rstN,
  input logic       cpuDone,
  input logic       cpuErr,
  input logic       tgtReq,
  input logic       tgtReady,
  input logic [3:0] tgtBe,
  input logic [7:0] tgtBus,
  input logic [5:0] tgtReg
);
  // R8
  req_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    tgtReq && !tgtReady |=> tgtReq);
  // R8
  done_after_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    tgtReq && tgtReady |=> cpuDone && !tgtReq);
  // R5
  be_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    tgtReq |-> tgtBe != 4'b0000);
  // R3
  fields_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    tgtReq && !tgtReady |=> $stable(tgtBus) && $stable(tgtReg) && $stable(tgtBe));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |=> !cpuDone);
  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuErr |-> cpuDone);
  // R9
  err_no_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuErr |-> !$past(tgtReq));
endmodule

bind cfgAccessPort cfgAccessPortChk u_chk (
  .clk(clk), .rstN(rstN), .cpuDone(cpuDone), .cpuErr(cpuErr), .tgtReq(tgtReq),
  .tgtReady(tgtReady), .tgtBe(tgtBe), .tgtBus(tgtBus), .tgtReg(tgtReg)
);

// File: tb/cfg_access_port_test.sv
module cfgAccessPort_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReq = 1'b0, cpuWrite = 1'b0;
  logic [7:0] cpuAddr = '0;
  logic [2:0] cpuSize = '0;
  logic [31:0] cpuWdata = '0;
  logic [31:0] cpuRdata;
  logic cpuDone, cpuErr, tgtReq, tgtWrite;
  logic [7:0] tgtBus;
  logic [4:0] tgtDev;
  logic [2:0] tgtFunc;
  logic [5:0] tgtReg;
  logic [3:0] tgtBe;
  logic [31:0] tgtWdata;
  logic tgtReady = 1'b0;
  logic [31:0] tgtRdata = '0;

  int nChecks = 0, nFails = 0;
  int tgtLat = 0, latCnt = 0, readyCount = 0;
  logic [7:0] mBus; logic [4:0] mDev; logic [2:0] mFunc; logic [5:0] mReg;
  logic [3:0] mBe; logic [31:0] mWdata; logic mWrite;

  always #4 clk = ~clk;

  cfgAccessPort uut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuSize(cpuSize), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata), .cpuDone(cpuDone), .cpuErr(cpuErr), .tgtReq(tgtReq),
    .tgtWrite(tgtWrite), .tgtBus(tgtBus), .tgtDev(tgtDev), .tgtFunc(tgtFunc),
    .tgtReg(tgtReg), .tgtBe(tgtBe), .tgtWdata(tgtWdata), .tgtReady(tgtReady),
    .tgtRdata(tgtRdata)
  );

  function automatic logic [31:0] pattern(input logic [7:0] b, input logic [4:0] d,
                                          input logic [2:0] f, input logic [5:0] r);
    return {b, 3'b000, d, 5'b00000, f, 2'b00, r} ^ 32'h5A3C_96F1;
  endfunction

  // Target model: answers after tgtLat wait cycles
  always @(negedge clk) begin
    if (tgtReq && !tgtReady) begin
      if (latCnt >= tgtLat) begin
        tgtReady <= 1'b1;
        tgtRdata <= pattern(tgtBus, tgtDev, tgtFunc, tgtReg);
        mBus <= tgtBus; mDev <= tgtDev; mFunc <= tgtFunc; mReg <= tgtReg;
        mBe <= tgtBe; mWdata <= tgtWdata; mWrite <= tgtWrite;
        readyCount <= readyCount + 1;
        latCnt <= 0;
      end else latCnt <= latCnt + 1;
    end else tgtReady <= 1'b0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [7:0] addr, input logic [2:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd,
                        output logic er, output int reqCycles, output int readies);
    int waitCnt = 0;
    int startReady;
    @(negedge clk);
    startReady = readyCount;
    cpuReq = 1'b1; cpuWrite = wr; cpuAddr = addr; cpuSize = sz; cpuWdata = wd;
    reqCycles = 0;
    do begin
      @(negedge clk);
      if (tgtReq) reqCycles++;
      waitCnt++;
    end while (!cpuDone && waitCnt < 50);
    rd = cpuRdata; er = cpuErr;
    readies = readyCount - startReady;
    cpuReq = 1'b0;
    chk("R10 done seen", {31'd0, cpuDone}, 32'd1);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    nFails++; nChecks++;
    $display("FAIL watchdog actual=%0d expected=<100000", cyc);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] rd, selVal, expRd, mask;
    logic er;
    int rc, rdy;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cpuDone", {31'd0, cpuDone}, 32'd0);
    chk("R1 cpuErr", {31'd0, cpuErr}, 32'd0);
    chk("R1 tgtReq", {31'd0, tgtReq}, 32'd0);
    rstN = 1'b1;
    access(1'b0, 8'h28, 3'd4, 32'h0, rd, er, rc, rdy);
    chk("R1 selector reset", rd, 32'h0);

    // R2 selector write/readback and bad-size rejection
    access(1'b1, 8'h28, 3'd4, 32'h7F12_3456, rd, er, rc, rdy);
    chk("R2 write err", {31'd0, er}, 32'd0);
    access(1'b0, 8'h28, 3'd4, 32'h0, rd, er, rc, rdy);
    chk("R2 readback", rd, 32'h7F12_3456);
    for (int s = 0; s < 8; s++) begin
      if (s == 4) continue;
      access(1'b1, 8'h28, 3'(s), 32'hFFFF_FFFF, rd, er, rc, rdy);
      chk("R2 bad size err", {31'd0, er}, 32'd1);
    end
    access(1'b1, 8'h2A, 3'd4, 32'hFFFF_FFFF, rd, er, rc, rdy);
    chk("R2 bad offset err", {31'd0, er}, 32'd1);
    access(1'b0, 8'h28, 3'd4, 32'h0, rd, er, rc, rdy);
    chk("R2 unchanged", rd, 32'h7F12_3456);

    // R4 gate bit clear: no cycle
    for (int o = 0; o < 4; o++) begin
      access(1'b0, 8'h2C + 8'(o), 3'd1, 32'h0, rd, er, rc, rdy);
      chk("R4 no req", 32'(rc), 32'd0);
      chk("R4 rdata zero", rd, 32'h0);
      chk("R4 no err", {31'd0, er}, 32'd0);
      access(1'b1, 8'h2C + 8'(o), 3'd1, 32'hAB, rd, er, rc, rdy);
      chk("R4 write no req", 32'(rc), 32'd0);
    end

    // R10 unmapped offset
    access(1'b0, 8'h10, 3'd4, 32'h0, rd, er, rc, rdy);
    chk("R10 unmapped rdata", rd, 32'h0);
    chk("R10 unmapped err", {31'd0, er}, 32'd0);
    chk("R10 unmapped no req", 32'(rc), 32'd0);

    // Main sweep
    for (int i = 0; i < 4; i++) begin
      logic [7:0] b; logic [4:0] d; logic [2:0] f; logic [5:0] r;
      b = 8'(i * 91 + 3); d = 5'(i * 7 + 1); f = 3'(i * 3 + 2); r = 6'(i * 13 + 5);
      selVal = {1'b1, 7'(i * 17), b, d, f, r, 2'(i)};
      access(1'b1, 8'h28, 3'd4, selVal, rd, er, rc, rdy);
      for (int s = 0; s < 8; s++) begin
        for (int o = 0; o < 4; o++) begin
          for (int w = 0; w < 2; w++) begin
            logic ok;
            logic [31:0] wd;
            tgtLat = (i + s + o + w) % 3;
            ok = (s == 1) || (s == 2 && o != 3) || (s == 4 && o == 0);
            wd = 32'hC3A5_1E00 + 32'(s * 16 + o * 4 + w);
            access(w[0], 8'h2C + 8'(o), 3'(s), wd, rd, er, rc, rdy);
            if (!ok) begin
              chk("R9 err", {31'd0, er}, 32'd1);
              chk("R9 no req", 32'(rc), 32'd0);
            end else begin
              chk("R9 no err", {31'd0, er}, 32'd0);
              chk("R8 req cycles", 32'(rc), 32'(tgtLat + 1));
              chk("R8 one ready before done", 32'(rdy), 32'd1);
              chk("R3 fields", {mBus, mDev, mFunc, mReg}, {b, d, f, r});
              chk("R5 be", {28'd0, mBe},
                  s == 1 ? 32'(4'b0001 << o) : s == 2 ? 32'(4'b0011 << o) : 32'hF);
              chk("R5 write dir", {31'd0, mWrite}, {31'd0, w[0]});
              if (w == 1) chk("R6 wdata", mWdata, wd << (8 * o));
              else begin
                mask = (s == 1) ? 32'hFF : (s == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
                expRd = (pattern(b, d, f, r) >> (8 * o)) & mask;
                chk("R7 rdata", rd, expRd);
              end
            end
          end
        end
      end
    end
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule